// File: doc/BRIEF.md
# GPIO Interrupt Line Router

The block turns a wide set of asynchronous GPIO pad inputs into a small number of interrupt request lines in the core clock domain. There are 82 pads and 12 output lines by default. Each output line has its own 8-bit source selector that picks one pad. It also has its own trigger setup: a level that follows the pad, a single edge (rising or falling), or a both-edge mode that fires on every transition. A single global enable bit gates every output.

Software configures the block through a plain word-addressed register port. Writes take effect on the clock edge where the write strobe is sampled. Reads are combinational from the address. Every pad passes through a two-flop synchronizer before any line selects it. The edge history of a line reloads whenever that line's configuration changes, and edge pulses are held off in that cycle, so reprogramming a line never produces a false interrupt.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register reads zero and all outputs are low.
- R2: While the global enable (bit 31 at offset 0x00) is clear, every output is held low, whatever the pads and the other settings are.
- R3: Fields read back what was last written and unused bits read zero. Writing all ones gives 0x80FFFFFF at 0x00, 0x00FF00FF at 0x04 to 0x18, and 0x00000FFF at 0x1C.
- R4: The register at offset 4*X (X = 1 to 6) holds the selector of line 2X-2 in bits [7:0] and the selector of line 2X-1 in bits [23:16]. Any pad from 0 to 81 can be chosen.
- R5: A selector value above 81 selects a constant-zero source.
- R6: In level mode (bit 12+i of 0x00 clear, bit i of 0x1C clear), output i equals the selected pad, inverted when bit i of 0x00 is set. It settles two clock edges after the pad changes.
- R7: In single-edge mode (bit 12+i set) with bit i clear, a rising pad transition gives exactly one high cycle on output i, visible after the second clock edge following the change. A falling transition gives nothing.
- R8: In single-edge mode with bit i set, only a falling transition gives a one-cycle pulse.
- R9: Bit i of offset 0x1C selects both-edge mode for line i: every transition pulses for one cycle, and the line's polarity and single-edge bits are ignored.
- R10: Changing a line's selector or mode never produces an edge pulse from the switch itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pads_in | input | 82 | Asynchronous GPIO pad inputs |
| irq_out | output | 12 | Interrupt request per line |

## Verification
A pad change driven on a falling clock edge is taken by the first synchronizer flop at the next rising edge and by the second at the rising edge after that. A level result is therefore due after two rising edges. An edge pulse is high for exactly the cycle after that second edge and has gone after the third. Register writes and the enable gate act at the edge that samples the strobe. The bench drives on falling edges and samples one half period later, checking the cycles just before, during and just after each of these points, so that a result one cycle early or late is caught.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int SEL_W    = 8;
  localparam int SEL_SPAN = 1 << SEL_W;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             low;
    logic             edge_mode;
    logic             both;
  } line_cfg_t;

  // transition test for edge-type lines
  function automatic logic edge_hit(line_cfg_t c, logic cur, logic prev);
    if (c.both) return cur ^ prev;
    if (c.low)  return prev & ~cur;
    return cur & ~prev;
  endfunction

  // request of one line before the global gate
  function automatic logic line_req(line_cfg_t c, logic cur, logic prev, logic quiet);
    if (c.both || c.edge_mode) return edge_hit(c, cur, prev) & ~quiet;
    return cur ^ c.low;
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 12,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic                        glb_en,
  output line_cfg_t [N_LINES-1:0]     cfg
);
  localparam int N_SEL   = N_LINES / 2;
  localparam int WIDX_W  = ADDR_W - 2;
  localparam int HI_SEL  = 16;
  localparam logic [WIDX_W-1:0] IDX_BOTH = WIDX_W'(N_SEL + 1);

  logic                   en_q;
  logic [N_LINES-1:0]     low_q, edge_q, both_q;
  logic [N_LINES-1:0][SEL_W-1:0] sel_q;
  logic [WIDX_W-1:0]      widx;
  logic                   unused_addr_bits;

  assign widx = addr[ADDR_W-1:2];
  assign unused_addr_bits = ^addr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      low_q  <= '0;
      edge_q <= '0;
      both_q <= '0;
      sel_q  <= '0;
    end else if (wr) begin
      if (widx == '0) begin
        en_q   <= wdata[DATA_W-1];
        low_q  <= wdata[N_LINES-1:0];
        edge_q <= wdata[2*N_LINES-1:N_LINES];
      end
      for (int r = 0; r < N_SEL; r++) begin
        if (widx == WIDX_W'(r + 1)) begin
          sel_q[2*r]   <= wdata[SEL_W-1:0];
          sel_q[2*r+1] <= wdata[HI_SEL +: SEL_W];
        end
      end
      if (widx == IDX_BOTH) both_q <= wdata[N_LINES-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (widx == '0) begin
      rdata[DATA_W-1]            = en_q;
      rdata[2*N_LINES-1:N_LINES] = edge_q;
      rdata[N_LINES-1:0]         = low_q;
    end
    for (int r = 0; r < N_SEL; r++) begin
      if (widx == WIDX_W'(r + 1)) begin
        rdata[SEL_W-1:0]      = sel_q[2*r];
        rdata[HI_SEL +: SEL_W] = sel_q[2*r+1];
      end
    end
    if (widx == IDX_BOTH) rdata[N_LINES-1:0] = both_q;
  end

  assign glb_en = en_q;

  for (genvar i = 0; i < N_LINES; i++) begin : g_cfg
    assign cfg[i].sel       = sel_q[i];
    assign cfg[i].low       = low_q[i];
    assign cfg[i].edge_mode = edge_q[i];
    assign cfg[i].both      = both_q[i];
  end
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
  import gpio_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_SPAN-1:0] pads_ext,
  input  line_cfg_t           cfg,
  input  logic                glb_en,
  output logic                cfg_chg,
  output logic                irq
);
  logic      cur, hist_q;
  line_cfg_t cfg_q;

  // codes past the last pad index land on zero-extended bits
  assign cur = pads_ext[cfg.sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      hist_q <= cur;
      cfg_q  <= cfg;
    end
  end

  assign cfg_chg = (cfg != cfg_q);
  assign irq     = glb_en & line_req(cfg, cur, hist_q, cfg_chg);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int N_PADS   = 82,
  parameter int N_LINES  = 12,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int N_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [N_PADS-1:0]  pads_in,
  output logic [N_LINES-1:0] irq_out
);
  logic                    glb_en;
  line_cfg_t [N_LINES-1:0] cfg;
  logic [N_LINES-1:0]      cfg_chg;
  logic [N_PADS-1:0]       pads_sync;
  logic [SEL_SPAN-1:0]     pads_ext;

  gpio_irq_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .glb_en(glb_en), .cfg(cfg)
  );

  gpio_irq_sync #(.W(N_PADS), .STAGES(N_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pads_in), .q(pads_sync)
  );

  assign pads_ext = SEL_SPAN'(pads_sync);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    gpio_irq_line line_i (
      .clk(clk), .rst_n(rst_n), .pads_ext(pads_ext), .cfg(cfg[i]),
      .glb_en(glb_en), .cfg_chg(cfg_chg[i]), .irq(irq_out[i])
    );
  end
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 12,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [DATA_W-1:0]       reg_wdata,
  input logic [N_LINES-1:0]      irq_out,
  input logic                    glb_en,
  input line_cfg_t [N_LINES-1:0] cfg,
  input logic [N_LINES-1:0]      cfg_chg
);
  localparam logic [ADDR_W-1:0] A_BOTH = ADDR_W'(4 * (N_LINES / 2 + 1));

  logic [N_LINES-1:0] both_v;
  always_comb for (int i = 0; i < N_LINES; i++) both_v[i] = cfg[i].both;

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> irq_out == '0);

  p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> irq_out == '0);

  p_both_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_BOTH) |=> both_v == $past(reg_wdata[N_LINES-1:0]));

  for (genvar i = 0; i < N_LINES; i++) begin : g_line_chk
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out[i] && cfg[i].edge_mode && !cfg[i].both) |=> !irq_out[i]);

    p_switch_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_chg[i] && (cfg[i].edge_mode || cfg[i].both)) |-> !irq_out[i]);
  end
endmodule

bind gpio_irq_router gpio_irq_router_chk #(
  .N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_out(irq_out), .glb_en(glb_en), .cfg(cfg),
  .cfg_chg(cfg_chg)
);

// File: tb/gpio_irq_router_tb_top.sv
module gpio_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [81:0] pads = '0;
  logic [11:0] irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pads_in(pads), .irq_out(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // pad was just driven on a falling edge: silent, one-cycle pulse, silent
  task automatic expect_pulse(logic [11:0] mask, string tag);
    step(1); chk({tag, " early"}, 32'(irq), 32'h0);
    step(1); chk({tag, " pulse"}, 32'(irq), 32'(mask));
    step(1); chk({tag, " after"}, 32'(irq), 32'h0);
  endtask

  task automatic expect_quiet(int n, string tag);
    logic [11:0] seen = '0;
    seen |= irq;
    for (int k = 0; k < n; k++) begin step(1); seen |= irq; end
    chk(tag, 32'(seen), 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 irq after reset", 32'(irq), 32'h0);
    for (int a = 0; a < 8; a++) rd(5'(4 * a), 32'h0, "R1 register reset");
  endtask

  task automatic t_readback;
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, 32'h80FF_FFFF, "R3 control word");
    wr(5'h00, 32'h0);
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, 32'h00FF_00FF, "R3 selector word");
    wr(5'h04, 32'h0);
    wr(5'h1C, 32'hFFFF_FFFF); rd(5'h1C, 32'h0000_0FFF, "R3 both-edge word");
    wr(5'h1C, 32'h0); rd(5'h1C, 32'h0, "R3 both-edge cleared");
  endtask

  task automatic t_level;
    wr(5'h00, 32'h8000_0000);
    wr(5'h04, 32'(40) << 16);
    @(negedge clk); pads[40] = 1'b1;
    step(1); chk("R6 level not yet", 32'(irq), 32'h0);
    step(1); chk("R4 R6 line1 from pad40", 32'(irq), 32'h002);
    wr(5'h00, 32'h8000_0002);
    chk("R6 inverted high pad", 32'(irq), 32'h0);
    @(negedge clk); pads[40] = 1'b0;
    step(2); chk("R6 inverted low pad", 32'(irq), 32'h002);
    wr(5'h00, 32'h8000_0000);
    chk("R6 back to active-high", 32'(irq), 32'h0);
    wr(5'h18, 32'd81);
    @(negedge clk); pads[81] = 1'b1;
    step(2); chk("R4 line10 from pad81", 32'(irq), 32'h400);
    @(negedge clk); pads[81] = 1'b0;
    wr(5'h18, 32'h0);
    step(2);
  endtask

  task automatic t_oob_gate;
    wr(5'h08, 32'd82);
    @(negedge clk); pads = ~82'd1;
    step(2); chk("R5 selector 82 reads zero", 32'(irq), 32'h002);
    wr(5'h00, 32'h8000_0004);
    chk("R5 zero source inverted", 32'(irq), 32'h006);
    wr(5'h00, 32'h0000_0004);
    chk("R2 global enable off", 32'(irq), 32'h0);
    step(3); chk("R2 stays off", 32'(irq), 32'h0);
    @(negedge clk); pads = '0;
    wr(5'h04, 32'h0); wr(5'h08, 32'h0);
    wr(5'h00, 32'h8000_0000);
    step(3);
  endtask

  task automatic t_edges;
    wr(5'h08, 32'(7) << 16);
    wr(5'h00, 32'h8000_8000);
    @(negedge clk); pads[7] = 1'b1;
    expect_pulse(12'h008, "R7 rising");
    @(negedge clk); pads[7] = 1'b0;
    expect_quiet(4, "R7 falling ignored");
    wr(5'h00, 32'h8000_8008);
    @(negedge clk); pads[7] = 1'b1;
    expect_quiet(4, "R8 rising ignored");
    @(negedge clk); pads[7] = 1'b0;
    expect_pulse(12'h008, "R8 falling");
    wr(5'h1C, 32'h008);
    @(negedge clk); pads[7] = 1'b1;
    expect_pulse(12'h008, "R9 both rise");
    @(negedge clk); pads[7] = 1'b0;
    expect_pulse(12'h008, "R9 both fall");
    wr(5'h1C, 32'h0);
    step(2);
  endtask

  task automatic t_switch;
    wr(5'h00, 32'h8000_8000);
    @(negedge clk); pads[9] = 1'b1;
    step(3);
    wr(5'h08, 32'(9) << 16);
    expect_quiet(4, "R10 selector switch");
    @(negedge clk); pads[9] = 1'b0;
    step(3);
    wr(5'h1C, 32'h008);
    wr(5'h08, 32'(7) << 16);
    @(negedge clk); pads[9] = 1'b1;
    step(3);
    wr(5'h08, 32'(9) << 16);
    expect_quiet(4, "R10 both-edge switch");
    wr(5'h1C, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_readback();
    t_level();
    t_oob_gate();
    t_edges();
    t_switch();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule